// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one 8-bit compare channel attached to an external timer. It watches the timer count on every timer tick and compares it with an active compare value. On an equal count it raises a one-cycle match flag, asks the timer to restart when in clear-on-compare mode, and moves a waveform pin according to a 2-bit output action. The timer itself, its prescaler and any interrupt logic stay outside. The channel only sees the count, the count direction, the tick enable and the top and bottom indications.

Four waveform modes are supported: normal, clear-on-compare, fast PWM and phase-correct PWM. In the two PWM modes a CPU write lands in a buffer and reaches the active compare only at a defined point of the count, so every PWM period uses a single compare value. In the other two modes the write goes straight to the active value. Two extra controls help software set the pin state safely:
- A force strobe drives the pin as though a match had happened, but raises no flag.
- A CPU write to the counter hides the match on the next tick. This lets software load the counter with the compare value without an immediate match.

Top module: `ocu_top`

## Requirements
- R1: After reset the pin, `match_flag`, `clr_timer` and `cmp_val` are all 0. The mode is normal (00) and the action is none (00).
- R2: A `cfg_wr` pulse loads `cfg_mode` (00 normal, 01 phase-correct PWM, 10 clear-on-compare, 11 fast PWM) and `cfg_act`. Both are used from the next clock cycle on.
- R3: In normal and clear-on-compare modes, an `ocr_wr` pulse puts `ocr_data` on `cmp_val` on the next cycle.
- R4: In the PWM modes, `ocr_wr` only fills a buffer, and `cmp_val` is unchanged by it. The buffer is copied to `cmp_val` on a tick with `at_bottom` in fast PWM, and on a tick with `at_top` in phase-correct PWM.
- R5: A tick with `cnt == cmp_val` that is not blocked is a match. One cycle later, `match_flag` is high for one cycle, in every mode.
- R6: `clr_timer` pulses together with `match_flag` only when the match occurred in clear-on-compare mode.
- R7: In normal and clear-on-compare modes a match applies the action to the pin: 00 leaves it, 01 toggles it, 10 clears it, 11 sets it.
- R8: In non-PWM modes a `force_cmp` pulse applies the same action to the pin as a match, but raises neither `match_flag` nor `clr_timer`. In PWM modes `force_cmp` has no effect.
- R9: A `cnt_wr` pulse blocks the match of the next tick, however many cycles later that tick comes. The pin, flag and clear request are then unchanged.
- R10: In fast PWM with action 10, the pin is set on a bottom tick and cleared on a match. Action 11 inverts both levels. When both happen on the same tick, the match wins. Actions 00 and 01 hold the pin.
- R11: In phase-correct PWM with action 10, the pin is cleared on a match while counting up (`cnt_down` = 0) and set on a match while counting down. Action 11 inverts this. Actions 00 and 01 hold the pin.
- R12: A new action is used for the events of the cycle after `cfg_wr`. This holds in PWM modes too, without waiting for a buffer load.
- R13: The pin keeps its level across a mode change. It moves only on a match, a force or a fast-PWM bottom tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer clock enable; the count is valid for this tick |
| cnt | input | 8 | Current timer count |
| cnt_down | input | 1 | Timer is counting down |
| at_top | input | 1 | Count is at its top value |
| at_bottom | input | 1 | Count is at zero |
| ocr_wr | input | 1 | CPU write strobe for the compare value |
| ocr_data | input | 8 | Compare value written by the CPU |
| cnt_wr | input | 1 | CPU is writing the timer counter |
| cfg_wr | input | 1 | CPU write strobe for mode and action |
| cfg_mode | input | 2 | Waveform mode to load |
| cfg_act | input | 2 | Output action to load |
| force_cmp | input | 1 | Force-compare strobe |
| pin | output | 1 | Waveform pin level |
| match_flag | output | 1 | One-cycle match pulse |
| clr_timer | output | 1 | Request to clear the timer (clear-on-compare) |
| cmp_val | output | 8 | Active compare value, also the timer top in clear-on-compare |

## Verification
Random ticks are mixed with counts biased toward the active compare value, zero and the maximum count. This separates real matches from near misses, and separates the PWM bottom event from a match when both fall on the same count. Random writes to the compare register arrive in all four modes. Comparing `cmp_val` then shows whether a write went to the buffer or straight to the active value, and whether the buffer load follows the bottom tick (fast PWM) or the top tick (phase-correct PWM). Directed sequences cover cases that random stimulus rarely hits: a counter write followed by idle cycles before the blocked tick, a force strobe in PWM mode, and an action change in the middle of a PWM period.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

  typedef enum logic [1:0] {
    WG_NORMAL = 2'b00,
    WG_PHASE  = 2'b01,
    WG_CTC    = 2'b10,
    WG_FAST   = 2'b11
  } wg_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } act_e;

  // Buffered (PWM) modes have the low mode bit set.
  function automatic logic mode_is_pwm(wg_mode_e m);
    return m[0];
  endfunction

  // Non-PWM output action applied to the current level.
  function automatic logic direct_action(act_e a, logic cur);
    logic r;
    case (a)
      ACT_TOGGLE: r = ~cur;
      ACT_CLEAR:  r = 1'b0;
      ACT_SET:    r = 1'b1;
      default:    r = cur;
    endcase
    return r;
  endfunction

  // PWM action is active only for the two upper action codes.
  function automatic logic pwm_connected(act_e a);
    return a[1];
  endfunction

  // Level driven on a PWM match: non-inverting clears when counting up,
  // the inverting code and the down-count both flip it.
  function automatic logic pwm_match_level(act_e a, logic down);
    return a[0] ^ down;
  endfunction

endpackage

// File: rtl/ocu_cmp_reg.sv
module ocu_cmp_reg
  import ocu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwm,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load_ev,
  output logic [W-1:0] active
);

  logic [W-1:0] buf_q;
  logic [W-1:0] act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (wr) buf_q <= wdata;
      if (wr && !pwm) act_q <= wdata;
      else if (load_ev) act_q <= buf_q;
    end
  end

  assign active = act_q;

endmodule

// File: rtl/ocu_match.sv
module ocu_match #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  output logic         match_ev,
  output logic         blk_q
);

  function automatic logic hit(logic [W-1:0] a, logic [W-1:0] b);
    return a == b;
  endfunction

  logic blk_r;

  always_ff @(posedge clk) begin
    if (!rst_n) blk_r <= 1'b0;
    else if (cnt_wr) blk_r <= 1'b1;
    else if (tick_en) blk_r <= 1'b0;
  end

  assign blk_q    = blk_r;
  assign match_ev = tick_en && !blk_r && hit(cnt, cmp);

endmodule

// File: rtl/ocu_wave.sv
module ocu_wave
  import ocu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wg_mode_e mode,
  input  act_e     act,
  input  logic     match_ev,
  input  logic     force_ev,
  input  logic     bottom_ev,
  input  logic     cnt_down,
  output logic     pin
);

  logic pin_q;
  logic pin_d;

  always_comb begin
    pin_d = pin_q;
    case (mode)
      WG_NORMAL, WG_CTC: begin
        if (match_ev || force_ev) pin_d = direct_action(act, pin_q);
      end
      WG_FAST: begin
        if (pwm_connected(act)) begin
          if (match_ev)       pin_d = pwm_match_level(act, 1'b0);
          else if (bottom_ev) pin_d = ~pwm_match_level(act, 1'b0);
        end
      end
      default: begin
        if (pwm_connected(act) && match_ev) pin_d = pwm_match_level(act, cnt_down);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin = pin_q;

endmodule

// File: rtl/ocu_top.sv
module ocu_top
  import ocu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic [W-1:0] cnt,
  input  logic         cnt_down,
  input  logic         at_top,
  input  logic         at_bottom,
  input  logic         ocr_wr,
  input  logic [W-1:0] ocr_data,
  input  logic         cnt_wr,
  input  logic         cfg_wr,
  input  logic [1:0]   cfg_mode,
  input  logic [1:0]   cfg_act,
  input  logic         force_cmp,
  output logic         pin,
  output logic         match_flag,
  output logic         clr_timer,
  output logic [W-1:0] cmp_val
);

  wg_mode_e mode_q;
  act_e     act_q;

  // Named internal events, also used by the bound checker.
  logic pwm;
  logic load_ev;
  logic match_ev;
  logic force_ev;
  logic bottom_ev;
  logic blk_q;
  logic flag_q;
  logic clr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= WG_NORMAL;
      act_q  <= ACT_NONE;
    end else if (cfg_wr) begin
      mode_q <= wg_mode_e'(cfg_mode);
      act_q  <= act_e'(cfg_act);
    end
  end

  assign pwm       = mode_is_pwm(mode_q);
  assign bottom_ev = tick_en && at_bottom && (mode_q == WG_FAST);
  assign load_ev   = tick_en && (((mode_q == WG_FAST) && at_bottom) ||
                                 ((mode_q == WG_PHASE) && at_top));
  assign force_ev  = force_cmp && !pwm;

  ocu_cmp_reg #(.W(W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm     (pwm),
    .wr      (ocr_wr),
    .wdata   (ocr_data),
    .load_ev (load_ev),
    .active  (cmp_val)
  );

  ocu_match #(.W(W)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .cnt_wr   (cnt_wr),
    .cnt      (cnt),
    .cmp      (cmp_val),
    .match_ev (match_ev),
    .blk_q    (blk_q)
  );

  ocu_wave u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_q),
    .act       (act_q),
    .match_ev  (match_ev),
    .force_ev  (force_ev),
    .bottom_ev (bottom_ev),
    .cnt_down  (cnt_down),
    .pin       (pin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      flag_q <= match_ev;
      clr_q  <= match_ev && (mode_q == WG_CTC);
    end
  end

  assign match_flag = flag_q;
  assign clr_timer  = clr_q;

endmodule

// File: rtl/ocu_chk.sv
module ocu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_en,
  input logic         match_flag,
  input logic         clr_timer,
  input logic         match_ev,
  input logic         force_ev,
  input logic         bottom_ev,
  input logic         load_ev,
  input logic         blk_q,
  input logic         pwm,
  input logic         pin,
  input logic [W-1:0] cmp_val
);

  AST_FLAG_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    match_flag |-> $past(tick_en)); // R5

  AST_CLR_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    clr_timer |-> match_flag); // R6

  AST_BLOCKED_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q && tick_en) |=> !match_flag); // R9

  AST_FORCE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ev && !match_ev) |=> !match_flag); // R8

  AST_PWM_CMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !load_ev) |=> $stable(cmp_val)); // R4

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_ev && !force_ev && !bottom_ev) |=> $stable(pin)); // R13

endmodule

bind ocu_top ocu_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .match_flag (match_flag),
  .clr_timer  (clr_timer),
  .match_ev   (match_ev),
  .force_ev   (force_ev),
  .bottom_ev  (bottom_ev),
  .load_ev    (load_ev),
  .blk_q      (blk_q),
  .pwm        (pwm),
  .pin        (pin),
  .cmp_val    (cmp_val)
);

// File: tb/tb_ocu_top.sv
module tb_ocu_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en, cnt_down, at_top, at_bottom;
  logic [7:0] cnt, ocr_data, cmp_val;
  logic       ocr_wr, cnt_wr, cfg_wr, force_cmp;
  logic [1:0] cfg_mode, cfg_act;
  logic       pin, match_flag, clr_timer;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // Bench model state, derived from the requirements.
  logic [1:0] e_mode, e_act;
  logic [7:0] e_buf, e_ocr;
  logic       e_blk, e_pin, e_flag, e_clr;

  always #4 clk = ~clk;

  ocu_top dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt(cnt), .cnt_down(cnt_down),
    .at_top(at_top), .at_bottom(at_bottom), .ocr_wr(ocr_wr), .ocr_data(ocr_data),
    .cnt_wr(cnt_wr), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_act(cfg_act),
    .force_cmp(force_cmp), .pin(pin), .match_flag(match_flag),
    .clr_timer(clr_timer), .cmp_val(cmp_val)
  );

  function automatic logic exp_direct(logic [1:0] a, logic cur);
    if (a == 2'b01) return !cur;
    if (a == 2'b10) return 1'b0;
    if (a == 2'b11) return 1'b1;
    return cur;
  endfunction

  task automatic check(string req, string what, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic idle_inputs();
    tick_en = 0; cnt = 8'h11; cnt_down = 0; at_top = 0; at_bottom = 0;
    ocr_wr = 0; ocr_data = 0; cnt_wr = 0; cfg_wr = 0; cfg_mode = 0;
    cfg_act = 0; force_cmp = 0;
  endtask

  // Advance the model by one clock edge using the inputs held now.
  task automatic model_edge();
    logic is_pwm, hit, frc, bot, ld, np;
    is_pwm = e_mode[0];
    hit = tick_en && (cnt == e_ocr) && !e_blk;
    frc = force_cmp && !is_pwm;
    bot = tick_en && at_bottom && (e_mode == 2'b11);
    ld  = tick_en && ((e_mode == 2'b11 && at_bottom) || (e_mode == 2'b01 && at_top));
    np  = e_pin;
    if (!is_pwm) begin
      if (hit || frc) np = exp_direct(e_act, e_pin);
    end else if (e_act[1]) begin
      if (e_mode == 2'b11) begin
        if (hit) np = (e_act == 2'b11);
        else if (bot) np = (e_act == 2'b10);
      end else if (hit) begin
        np = cnt_down ? (e_act == 2'b10) : (e_act == 2'b11);
      end
    end
    e_flag = hit;
    e_clr  = hit && (e_mode == 2'b10);
    e_pin  = np;
    if (ocr_wr && !is_pwm) e_ocr = ocr_data;
    else if (ld) e_ocr = e_buf;
    if (ocr_wr) e_buf = ocr_data;
    if (cnt_wr) e_blk = 1'b1;
    else if (tick_en) e_blk = 1'b0;
    if (cfg_wr) begin
      e_mode = cfg_mode;
      e_act  = cfg_act;
    end
  endtask

  task automatic step(string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(req, "pin", {7'd0, pin}, {7'd0, e_pin});
    check(req, "match_flag", {7'd0, match_flag}, {7'd0, e_flag});
    check(req, "clr_timer", {7'd0, clr_timer}, {7'd0, e_clr});
    check(req, "cmp_val", cmp_val, e_ocr);
    idle_inputs();
  endtask

  task automatic set_cfg(logic [1:0] m, logic [1:0] a, string req);
    cfg_wr = 1; cfg_mode = m; cfg_act = a;
    step(req);
  endtask

  task automatic wr_cmp(logic [7:0] v, string req);
    ocr_wr = 1; ocr_data = v;
    step(req);
  endtask

  task automatic do_tick(logic [7:0] c, logic dn, string req);
    tick_en = 1; cnt = c; cnt_down = dn;
    at_top = (c == 8'hFF); at_bottom = (c == 8'h00);
    step(req);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    e_mode = 0; e_act = 0; e_buf = 0; e_ocr = 0;
    e_blk = 0; e_pin = 0; e_flag = 0; e_clr = 0;
    repeat (3) @(negedge clk);
    // R1: reset values, literal expectations
    check("R1", "pin", {7'd0, pin}, 8'h00);
    check("R1", "match_flag", {7'd0, match_flag}, 8'h00);
    check("R1", "clr_timer", {7'd0, clr_timer}, 8'h00);
    check("R1", "cmp_val", cmp_val, 8'h00);
    rst_n = 1;
    step("R1");

    // R2/R3/R7: normal mode, action set, direct write
    set_cfg(2'b00, 2'b11, "R2");
    wr_cmp(8'h40, "R3");
    check("R3", "cmp_val direct", cmp_val, 8'h40);
    do_tick(8'h3F, 0, "R5");
    do_tick(8'h40, 0, "R5");
    check("R7", "pin set on match", {7'd0, pin}, 8'h01);
    check("R5", "flag pulse", {7'd0, match_flag}, 8'h01);
    step("R5");
    check("R5", "flag one cycle", {7'd0, match_flag}, 8'h00);
    set_cfg(2'b00, 2'b01, "R7");
    do_tick(8'h40, 0, "R7");
    do_tick(8'h40, 0, "R7");

    // R6/R8: clear-on-compare, force strobe
    set_cfg(2'b10, 2'b11, "R6");
    do_tick(8'h40, 0, "R6");
    check("R6", "clr_timer", {7'd0, clr_timer}, 8'h01);
    set_cfg(2'b10, 2'b10, "R8");
    force_cmp = 1; step("R8");
    check("R8", "forced clear", {7'd0, pin}, 8'h00);
    check("R8", "no flag on force", {7'd0, match_flag}, 8'h00);

    // R9: counter write blocks the next tick, even after idle cycles
    cnt_wr = 1; step("R9");
    step("R9"); step("R9");
    set_cfg(2'b10, 2'b11, "R9");
    do_tick(8'h40, 0, "R9");
    check("R9", "blocked match", {7'd0, match_flag}, 8'h00);
    do_tick(8'h40, 0, "R9");
    check("R9", "next tick matches", {7'd0, match_flag}, 8'h01);

    // R4/R10: fast PWM buffering and levels
    set_cfg(2'b11, 2'b10, "R10");
    wr_cmp(8'h80, "R4");
    check("R4", "buffered, unchanged", cmp_val, 8'h40);
    do_tick(8'h40, 0, "R4");
    do_tick(8'h00, 0, "R4");
    check("R4", "loaded at bottom", cmp_val, 8'h80);
    check("R10", "set at bottom", {7'd0, pin}, 8'h01);
    do_tick(8'h80, 0, "R10");
    check("R10", "clear on match", {7'd0, pin}, 8'h00);
    force_cmp = 1; step("R8");
    set_cfg(2'b11, 2'b11, "R12");
    do_tick(8'h00, 0, "R12");
    check("R12", "inverted at bottom", {7'd0, pin}, 8'h00);
    wr_cmp(8'h00, "R10");
    do_tick(8'h00, 0, "R10");
    do_tick(8'h00, 0, "R10");

    // R11: phase-correct, load at top
    set_cfg(2'b01, 2'b10, "R11");
    wr_cmp(8'h30, "R4");
    do_tick(8'hFF, 1, "R4");
    check("R4", "loaded at top", cmp_val, 8'h30);
    do_tick(8'h30, 1, "R11");
    check("R11", "set on down match", {7'd0, pin}, 8'h01);
    do_tick(8'h30, 0, "R11");
    check("R11", "clear on up match", {7'd0, pin}, 8'h00);
    set_cfg(2'b01, 2'b11, "R12");
    do_tick(8'h30, 0, "R11");

    // R13: mode change keeps level
    set_cfg(2'b00, 2'b00, "R13");
    check("R13", "held over mode change", {7'd0, pin}, 8'h01);

    // Random phase, fixed seed
    void'($urandom(32'd20240607));
    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      tick_en = ($urandom_range(0, 1) == 1);
      case (sel)
        0, 1, 2, 3: cnt = e_ocr;
        4:          cnt = 8'h00;
        5:          cnt = 8'hFF;
        default:    cnt = 8'($urandom);
      endcase
      at_top    = (cnt == 8'hFF);
      at_bottom = (cnt == 8'h00);
      cnt_down  = ($urandom_range(0, 1) == 1);
      ocr_wr    = ($urandom_range(0, 15) == 0);
      ocr_data  = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
      cnt_wr    = ($urandom_range(0, 19) == 0);
      cfg_wr    = ($urandom_range(0, 24) == 0);
      cfg_mode  = 2'($urandom);
      cfg_act   = 2'($urandom);
      force_cmp = ($urandom_range(0, 15) == 0);
      step("R5");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule